// File: doc/BRIEF.md
# Programmable ADC Step Sequencer

This block runs a list of analog conversions back to back on an external converter. No processor is needed between steps. Software fills a small table of step slots while the sequencer is disabled. Each slot names an input channel and carries four flags: differential mode, temperature-sensor select, interrupt request and stop-here. Software then sets the enable and pulses initiate. The sequencer walks the slots from slot 0 and hands each slot's channel and mode to the converter through a start/done handshake. Every result goes into a result FIFO that has one entry per slot.

The walk stops after the first slot whose stop flag is set. If no slot has the flag, the walk stops after the last slot. A step whose interrupt flag is set raises a sticky interrupt status bit when its result arrives. Software clears that bit with a write-one-to-clear input. When a result arrives and the FIFO is already full, the result is discarded, a sticky overflow flag is set and the walk carries on.

Top module: `adc_step_sequencer`

## Requirements
- R1: A slot write (`cfg_we` with slot index, channel and the four flags) is stored only while `seq_enable` is low and `busy` is low. A write made while `seq_enable` is high is ignored, and the next sequence still uses the old slot contents.
- R2: An `seq_initiate` pulse while `seq_enable` is low is ignored. `busy` stays low and no `conv_start` is issued.
- R3: Each step raises `conv_start` for exactly one cycle. `conv_chan`, `conv_diff` and `conv_temp` show that slot's values and stay unchanged until the step's `conv_done`. The next `conv_start` follows only after that `conv_done`. The first `conv_start` comes in the cycle right after the accepted initiate.
- R4: Steps run in order from slot 0. The sequence ends after the first slot whose stop flag is set, and later slots are not converted.
- R5: If no slot has its stop flag set, the sequence ends after slot `NUM_SLOTS-1`.
- R6: Each `conv_result` is written to the FIFO as a 32-bit word. Bits [11:0] hold the result and bits [31:12] are zero. Words leave in arrival order: `fifo_word` shows the oldest word, and `fifo_pop` removes it.
- R7: A result that arrives while `fifo_level` equals `NUM_SLOTS` is dropped. `overflow` then goes high and stays high until reset, and the sequence continues. The stored words are not changed.
- R8: `irq_status` goes high in the cycle after `conv_done` for a step whose interrupt flag is set. Steps without the flag do not set it. Any combination of steps may carry the flag.
- R9: `irq_clear` clears `irq_status` at the next edge. If a set and a clear happen in the same cycle, the set wins.
- R10: `busy` is high from the first `conv_start` through the cycle of the final `conv_done`, and low in the cycle after it. An initiate pulse while `busy` is high is ignored.
- R11: The same channel may appear in several slots of one sequence, and each of those slots is converted.
- R12: After reset, `busy`, `conv_start`, `overflow` and `irq_status` are 0, `fifo_empty` is 1 and `fifo_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_enable | input | 1 | Arms the sequencer; slot writes are blocked while it is high |
| seq_initiate | input | 1 | One-cycle start request |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | IDX_W | Slot index to write |
| cfg_chan | input | 4 | Channel select for the slot |
| cfg_diff | input | 1 | Differential mode flag |
| cfg_temp | input | 1 | Temperature-sensor select flag |
| cfg_irq_en | input | 1 | Interrupt-on-completion flag |
| cfg_last | input | 1 | Stop-after-this-slot flag |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the current step |
| conv_diff | output | 1 | Differential mode for the current step |
| conv_temp | output | 1 | Temperature-sensor select for the current step |
| conv_done | input | 1 | Converter finished; `conv_result` is valid |
| conv_result | input | 12 | Conversion result |
| fifo_pop | input | 1 | Remove the oldest FIFO word |
| fifo_word | output | 32 | Oldest FIFO word, zero-extended result |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds NUM_SLOTS words |
| fifo_level | output | CNT_W | Number of words held |
| overflow | output | 1 | Sticky result-dropped flag |
| irq_status | output | 1 | Sticky interrupt status |
| irq_clear | input | 1 | Write-one-to-clear for `irq_status` |
| busy | output | 1 | Sequence in progress |

## Verification
The converter model records the channel, mode and sequence position of every start. The bench can then compare slot lists that stop early against lists that run through every slot. It also uses lists that repeat a channel and lists that mix differential and temperature flags, which shows whether the sequencer stops at the right slot and reads the right fields. Running a full list twice without popping separates correct dropping from overwriting, because the words left in the FIFO must be the ones from the first run. Interrupt patterns that flag alternate steps, combined with a clear that lands on the same edge as a set, show whether each step sets its own flag and whether the set wins.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int unsigned CHAN_W = 4;
    localparam int unsigned RES_W  = 12;
    localparam int unsigned WORD_W = 32;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              diff;
        logic              temp;
        logic              irq_en;
        logic              last;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/seq_slot_table.sv
module seq_slot_table
    import seq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_slot,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_t            rd_slot
);
    slot_t slots_q [NUM_SLOTS];
    slot_t slots_d [NUM_SLOTS];

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            slots_d[i] = slots_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                slots_d[i] = wr_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                slots_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                slots_q[i] <= slots_d[i];
            end
        end
    end

    // Read mux; an index beyond the table yields an empty slot
    always_comb begin
        rd_slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_slot = slots_q[i];
            end
        end
    end
endmodule

// File: rtl/seq_result_fifo.sv
module seq_result_fifo
    import seq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = 3,
    parameter int unsigned CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [RES_W-1:0]  push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  level,
    output logic              overflow
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t         st_q, st_d;
    logic [RES_W-1:0] mem_q [DEPTH];
    logic [RES_W-1:0] mem_d [DEPTH];
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        if (push && !do_push) begin
            st_d.ovf = 1'b1;
        end
        if (do_push) begin
            mem_d[st_q.wr] = push_data;
            st_d.wr        = bump(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = bump(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign head_word = {{(WORD_W - RES_W){1'b0}}, mem_q[st_q.rd]};
    assign empty     = (st_q.cnt == '0);
    assign full      = (st_q.cnt == CNT_W'(DEPTH));
    assign level     = st_q.cnt;
    assign overflow  = st_q.ovf;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             initiate,
    input  slot_t            cur_slot,
    output logic [IDX_W-1:0] step_idx,
    output logic             conv_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             push,
    output logic [RES_W-1:0] push_data,
    output logic             irq_set,
    output logic             busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] step;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        push    = 1'b0;
        irq_set = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (enable && initiate) begin
                    st_d.state = ST_ISSUE;
                    st_d.step  = '0;
                end
            end
            ST_ISSUE: begin
                st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    push    = 1'b1;
                    irq_set = cur_slot.irq_en;
                    if (cur_slot.last || (st_q.step == LAST_IDX)) begin
                        st_d.state = ST_IDLE;
                    end else begin
                        st_d.step  = st_q.step + 1'b1;
                        st_d.state = ST_ISSUE;
                    end
                end
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, step: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_idx   = st_q.step;
    assign conv_start = (st_q.state == ST_ISSUE);
    assign busy       = (st_q.state != ST_IDLE);
    assign push_data  = conv_result;
endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_enable,
    input  logic              seq_initiate,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_slot,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic              cfg_diff,
    input  logic              cfg_temp,
    input  logic              cfg_irq_en,
    input  logic              cfg_last,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_diff,
    output logic              conv_temp,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              fifo_pop,
    output logic [WORD_W-1:0] fifo_word,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [CNT_W-1:0]  fifo_level,
    output logic              overflow,
    output logic              irq_status,
    input  logic              irq_clear,
    output logic              busy
);
    slot_t            wr_slot;
    slot_t            cur_slot;
    logic [IDX_W-1:0] step_idx;
    logic             cfg_accept;
    logic             push_w;
    logic [RES_W-1:0] push_data_w;
    logic             irq_set_w;
    logic             busy_w;
    logic             irq_d, irq_q;

    // Slot writes only land while disarmed and idle
    assign cfg_accept = cfg_we && !seq_enable && !busy_w;
    assign wr_slot    = '{chan: cfg_chan, diff: cfg_diff, temp: cfg_temp,
                          irq_en: cfg_irq_en, last: cfg_last};

    seq_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_accept),
        .wr_idx  (cfg_slot),
        .wr_slot (wr_slot),
        .rd_idx  (step_idx),
        .rd_slot (cur_slot)
    );

    seq_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (seq_enable),
        .initiate    (seq_initiate),
        .cur_slot    (cur_slot),
        .step_idx    (step_idx),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .push        (push_w),
        .push_data   (push_data_w),
        .irq_set     (irq_set_w),
        .busy        (busy_w)
    );

    seq_result_fifo #(
        .DEPTH (NUM_SLOTS),
        .PTR_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_w),
        .push_data (push_data_w),
        .pop       (fifo_pop),
        .head_word (fifo_word),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level     (fifo_level),
        .overflow  (overflow)
    );

    // Interrupt status: set dominates clear
    always_comb begin
        irq_d = irq_q;
        if (irq_clear) begin
            irq_d = 1'b0;
        end
        if (irq_set_w) begin
            irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    // Slot contents are frozen while busy, so the table drives the converter directly
    assign conv_chan  = cur_slot.chan;
    assign conv_diff  = cur_slot.diff;
    assign conv_temp  = cur_slot.temp;
    assign irq_status = irq_q;
    assign busy       = busy_w;
endmodule

// File: rtl/seq_sva.sv
module seq_sva
    import seq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_enable,
    input logic              seq_initiate,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              conv_diff,
    input logic              conv_temp,
    input logic [CNT_W-1:0]  fifo_level,
    input logic              overflow,
    input logic              irq_set,
    input logic              irq_clear,
    input logic              irq_status,
    input logic              busy
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R3

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_start) |-> ($stable(conv_chan) && $stable(conv_diff) && $stable(conv_temp))); // R3

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R10

    AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(seq_enable && seq_initiate)) |=> !conv_start); // R2

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= CNT_W'(NUM_SLOTS)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R7

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq_status); // R9

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !irq_set) |=> !irq_status); // R9
endmodule

bind adc_step_sequencer seq_sva #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .seq_enable   (seq_enable),
    .seq_initiate (seq_initiate),
    .conv_start   (conv_start),
    .conv_chan    (conv_chan),
    .conv_diff    (conv_diff),
    .conv_temp    (conv_temp),
    .fifo_level   (fifo_level),
    .overflow     (overflow),
    .irq_set      (irq_set_w),
    .irq_clear    (irq_clear),
    .irq_status   (irq_status),
    .busy         (busy)
);

// File: tb/tb_adc_step_sequencer.sv
`timescale 1ns/1ps
module tb_adc_step_sequencer;
    localparam int NS    = 8;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seq_enable, seq_initiate, cfg_we;
    logic [IDX_W-1:0] cfg_slot;
    logic [3:0]  cfg_chan;
    logic        cfg_diff, cfg_temp, cfg_irq_en, cfg_last;
    logic        conv_start, conv_diff, conv_temp, conv_done;
    logic [3:0]  conv_chan;
    logic [11:0] conv_result;
    logic        fifo_pop, fifo_empty, fifo_full, overflow, irq_status, irq_clear, busy;
    logic [31:0] fifo_word;
    logic [CNT_W-1:0] fifo_level;

    always #2.5 clk = ~clk;

    adc_step_sequencer #(.NUM_SLOTS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .seq_enable(seq_enable), .seq_initiate(seq_initiate),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_chan(cfg_chan), .cfg_diff(cfg_diff),
        .cfg_temp(cfg_temp), .cfg_irq_en(cfg_irq_en), .cfg_last(cfg_last),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_diff(conv_diff),
        .conv_temp(conv_temp), .conv_done(conv_done), .conv_result(conv_result),
        .fifo_pop(fifo_pop), .fifo_word(fifo_word), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_level(fifo_level), .overflow(overflow),
        .irq_status(irq_status), .irq_clear(irq_clear), .busy(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Converter model state (owned by the model process)
    int          n_start = 0;
    int          n_done  = 0;
    int          wait_cnt;
    logic        pending;
    logic [3:0]  st_chan [0:127];
    logic        st_diff [0:127];
    logic        st_temp [0:127];
    logic [11:0] res_log [0:127];
    logic        irq_log [0:127];
    logic        busy_log[0:127];
    logic [3:0]  cur_chan;
    logic        cur_diff, cur_temp;
    int          clr_seen = 0;

    // Model controls (owned by the main process)
    int   lat = 2;
    logic auto_clear = 1'b0;
    logic clr_with_done = 1'b0;
    int   clr_req = 0;

    initial begin
        conv_done   = 1'b0;
        conv_result = '0;
        irq_clear   = 1'b0;
        pending     = 1'b0;
        wait_cnt    = 0;
        forever begin
            @(negedge clk);
            irq_clear = 1'b0;
            if (conv_done) begin
                conv_done = 1'b0;
                irq_log[n_done-1]  = irq_status;
                busy_log[n_done-1] = busy;
                if (auto_clear) irq_clear = 1'b1;
            end
            if (clr_req != clr_seen) begin
                irq_clear = 1'b1;
                clr_seen  = clr_req;
            end
            if (pending) begin
                if (wait_cnt <= 1) begin
                    conv_result     = {cur_chan, cur_diff, cur_temp, 6'(n_done)};
                    conv_done       = 1'b1;
                    res_log[n_done] = conv_result;
                    n_done++;
                    pending = 1'b0;
                    if (clr_with_done) irq_clear = 1'b1;
                end else begin
                    wait_cnt--;
                end
            end
            if (conv_start) begin
                st_chan[n_start] = conv_chan;
                st_diff[n_start] = conv_diff;
                st_temp[n_start] = conv_temp;
                cur_chan = conv_chan;
                cur_diff = conv_diff;
                cur_temp = conv_temp;
                n_start++;
                pending  = 1'b1;
                wait_cnt = lat;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [3:0] ch, input logic d,
                             input logic t, input logic ie, input logic lst);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = IDX_W'(idx); cfg_chan = ch;
        cfg_diff = d; cfg_temp = t; cfg_irq_en = ie; cfg_last = lst;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_slots();
        seq_enable = 1'b0;
        for (int i = 0; i < NS; i++) cfg_write(i, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_seq();
        @(negedge clk);
        seq_initiate = 1'b1;
        @(negedge clk);
        seq_initiate = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pop_check(input string req, input int idx);
        @(negedge clk);
        check(req, {31'd0, fifo_empty}, 32'd0);
        check(req, fifo_word, {20'd0, res_log[idx]});
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12 busy", {31'd0, busy}, 32'd0);
        check("R12 start", {31'd0, conv_start}, 32'd0);
        check("R12 empty", {31'd0, fifo_empty}, 32'd1);
        check("R12 level", {28'd0, fifo_level}, 32'd0);
        check("R12 ovf", {31'd0, overflow}, 32'd0);
        check("R12 irq", {31'd0, irq_status}, 32'd0);
    endtask

    task automatic t_end_early();
        int bs, bd;
        clear_slots();
        cfg_write(0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_write(1, 4'd7, 1'b1, 1'b0, 1'b0, 1'b0);
        cfg_write(2, 4'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        cfg_write(3, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0);
        seq_enable = 1'b1;
        bs = n_start; bd = n_done;
        run_seq();
        check("R4 step count", 32'(n_start - bs), 32'd3);
        check("R11 chan s0", {28'd0, st_chan[bs]}, 32'd3);
        check("R3 chan s1", {28'd0, st_chan[bs+1]}, 32'd7);
        check("R3 diff s1", {31'd0, st_diff[bs+1]}, 32'd1);
        check("R11 chan s2", {28'd0, st_chan[bs+2]}, 32'd3);
        check("R3 temp s2", {31'd0, st_temp[bs+2]}, 32'd1);
        check("R6 level", {28'd0, fifo_level}, 32'd3);
        for (int k = 0; k < 3; k++) pop_check("R6 word", bd + k);
        check("R6 drained", {31'd0, fifo_empty}, 32'd1);
    endtask

    task automatic t_full_list();
        int bs, bd;
        clear_slots();
        for (int i = 0; i < NS; i++) cfg_write(i, 4'(i + 1), 1'b0, 1'b0, 1'b0, 1'b0);
        seq_enable = 1'b1;
        bs = n_start; bd = n_done;
        run_seq();
        check("R5 step count", 32'(n_start - bs), 32'(NS));
        for (int i = 0; i < NS; i++) check("R5 order", {28'd0, st_chan[bs+i]}, 32'(i + 1));
        check("R6 full", {31'd0, fifo_full}, 32'd1);
        for (int k = 0; k < NS; k++) pop_check("R6 fifo order", bd + k);
    endtask

    task automatic t_unarmed();
        int bs;
        seq_enable = 1'b0;
        bs = n_start;
        @(negedge clk); seq_initiate = 1'b1;
        @(negedge clk); seq_initiate = 1'b0;
        check("R2 busy", {31'd0, busy}, 32'd0);
        repeat (6) @(negedge clk);
        check("R2 no start", 32'(n_start - bs), 32'd0);
    endtask

    task automatic t_cfg_locked();
        int bs, bd;
        clear_slots();
        cfg_write(0, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        seq_enable = 1'b1;
        cfg_write(0, 4'd12, 1'b0, 1'b0, 1'b0, 1'b1);
        bs = n_start; bd = n_done;
        run_seq();
        check("R1 locked chan", {28'd0, st_chan[bs]}, 32'd2);
        seq_enable = 1'b0;
        cfg_write(0, 4'd12, 1'b0, 1'b0, 1'b0, 1'b1);
        seq_enable = 1'b1;
        run_seq();
        check("R1 new chan", {28'd0, st_chan[bs+1]}, 32'd12);
        pop_check("R1 word", bd);
        pop_check("R1 word", bd + 1);
    endtask

    task automatic t_busy();
        int bs, bd;
        clear_slots();
        for (int i = 0; i < 4; i++) cfg_write(i, 4'(i + 4), 1'b0, 1'b0, 1'b0, i == 3);
        seq_enable = 1'b1;
        lat = 3;
        bs = n_start; bd = n_done;
        @(negedge clk); seq_initiate = 1'b1;
        @(negedge clk); seq_initiate = 1'b0;
        check("R10 busy rises", {31'd0, busy}, 32'd1);
        check("R3 first start", {31'd0, conv_start}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); seq_initiate = 1'b1;
            @(negedge clk); seq_initiate = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (8) @(negedge clk);
        check("R10 no restart", 32'(n_start - bs), 32'd4);
        check("R10 busy mid", {31'd0, busy_log[bd+2]}, 32'd1);
        check("R10 busy falls", {31'd0, busy_log[bd+3]}, 32'd0);
        lat = 2;
        for (int k = 0; k < 4; k++) pop_check("R10 word", bd + k);
    endtask

    task automatic t_irq_steps();
        int bd;
        clear_slots();
        cfg_write(0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        cfg_write(1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_write(2, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        seq_enable = 1'b1;
        auto_clear = 1'b1;
        bd = n_done;
        run_seq();
        auto_clear = 1'b0;
        check("R8 step0 irq", {31'd0, irq_log[bd]}, 32'd1);
        check("R8 step1 no irq", {31'd0, irq_log[bd+1]}, 32'd0);
        check("R8 step2 irq", {31'd0, irq_log[bd+2]}, 32'd1);
        check("R9 cleared", {31'd0, irq_status}, 32'd0);
        for (int k = 0; k < 3; k++) pop_check("R8 word", bd + k);
    endtask

    task automatic t_irq_prio();
        int bd;
        clear_slots();
        cfg_write(0, 4'd5, 1'b0, 1'b0, 1'b1, 1'b1);
        seq_enable = 1'b1;
        clr_with_done = 1'b1;
        bd = n_done;
        run_seq();
        clr_with_done = 1'b0;
        check("R9 set wins", {31'd0, irq_log[bd]}, 32'd1);
        check("R9 still set", {31'd0, irq_status}, 32'd1);
        clr_req++;
        repeat (3) @(negedge clk);
        check("R9 clear", {31'd0, irq_status}, 32'd0);
        pop_check("R9 word", bd);
    endtask

    task automatic t_overflow();
        int bs, bd;
        clear_slots();
        for (int i = 0; i < NS; i++) cfg_write(i, 4'(15 - i), 1'b0, 1'b0, 1'b0, 1'b0);
        seq_enable = 1'b1;
        bs = n_start; bd = n_done;
        run_seq();
        check("R7 no ovf yet", {31'd0, overflow}, 32'd0);
        run_seq();
        check("R7 continues", 32'(n_start - bs), 32'(2 * NS));
        check("R7 ovf", {31'd0, overflow}, 32'd1);
        check("R7 level", {28'd0, fifo_level}, 32'(NS));
        for (int k = 0; k < NS; k++) pop_check("R7 kept word", bd + k);
        check("R7 ovf sticky", {31'd0, overflow}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; seq_enable = 1'b0; seq_initiate = 1'b0; cfg_we = 1'b0;
        cfg_slot = '0; cfg_chan = '0; cfg_diff = 1'b0; cfg_temp = 1'b0;
        cfg_irq_en = 1'b0; cfg_last = 1'b0; fifo_pop = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_end_early();
        t_full_list();
        t_unarmed();
        t_cfg_locked();
        t_busy();
        t_irq_steps();
        t_irq_prio();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule